// File: doc/BRIEF.md
# Consumer-Electronics-Control Follower Acknowledge Generator

This block sits beside a bit receiver on a single-wire, open-drain consumer-electronics-control bus and answers the acknowledge slot as a follower. The companion receiver flags when the next falling edge belongs to an acknowledge bit and says whether the block is a header or a data block. For a header it also supplies the destination address. The block samples the filtered bus level on a slow sample tick and finds the initiator's falling edge. If the block is addressed to the local logical address, it pulls the line low for a fixed number of ticks after a programmable noise-cancel offset.

After each acknowledge window it raises a completion strobe. It then watches for the next bit. If no falling edge arrives within a selectable number of ticks, it raises a timeout strobe. Receive-error pulses from the companion receiver are turned into an interrupt strobe unless suppression is enabled. A new start bit, or reset, returns the block to idle and releases the line.

Top module: `cec_ack_responder`

## Requirements
- R1: Once the drive starts, `pull_low` stays high for exactly 50 sample ticks (200 clocks at one tick per four clocks) and is low in the cycle `irq_ack_done` is high.
- R2: The drive starts `nc_dly` ticks (0 to 3) after the tick that detects the acknowledge falling edge, and `pull_low` changes only on sample-tick cycles, on `start_det` or on reset.
- R3: In a header block (`hdr_blk`=1) the line is driven only if `blk_dest` equals `my_addr`; on a mismatch `pull_low` stays 0 for the whole window.
- R4: In a data block (`hdr_blk`=0) the line is driven only if the most recent header since the last start bit matched the local address.
- R5: A falling edge is a sample of 1 followed, at the next tick, by a sample of 0. Level changes between ticks, lows with no preceding high sample, and edges while `ack_next`=0 start no drive.
- R6: `irq_ack_done` is a one-cycle pulse at the tick ending the window, `nc_dly`+50 ticks after the edge, whether or not the line was driven; it never coincides with `irq_timeout`.
- R7: After a window, if no falling edge is seen within 48×(`tmo_sel`+1) ticks, `irq_timeout` pulses for one cycle and the block goes idle; an earlier falling edge cancels the timeout.
- R8: `irq_rx_err` pulses one cycle after any `err_in` bit is high (bit 0 maximum bit-cycle error, bit 1 overrun, bit 2 waveform error) when `err_mask`=0; when `err_mask`=1 it stays 0.
- R9: Reset or `start_det` releases the line at once, clears the header-match memory and abandons any window or timeout in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_tick | input | 1 | One-cycle sample enable at the bus sample rate |
| bus_lvl | input | 1 | Filtered bus level |
| start_det | input | 1 | Start bit seen by the receiver |
| ack_next | input | 1 | Next falling edge is an acknowledge bit |
| hdr_blk | input | 1 | Current block is a header block |
| blk_dest | input | 4 | Destination address of the header |
| my_addr | input | 4 | Local logical address |
| nc_dly | input | 2 | Noise-cancel start offset in ticks |
| tmo_sel | input | 2 | Timeout length select |
| err_mask | input | 1 | Suppress receive-error interrupt |
| err_in | input | 3 | Receive-error pulses from the receiver |
| pull_low | output | 1 | Open-drain pull-low enable |
| irq_ack_done | output | 1 | Acknowledge window completed |
| irq_timeout | output | 1 | Following bit did not arrive in time |
| irq_rx_err | output | 1 | Receive-error interrupt strobe |

## Verification
The hardest state to reach is a data-block acknowledge after the header-match memory has been cleared mid-drive by a start bit. Reaching it needs a matching header, an abort inside the hold, and then a data block with no new header between them. The bench builds this sequence directly. It also places level glitches between two sample ticks by aligning the stimulus to the tick phase. A behavioural per-tick model checks every output on every clock, so the noise-cancel offset and the timeout length are both checked to the exact tick.

// File: rtl/cec_ack_pkg.sv
// Shared types for the acknowledge generator.
package cec_ack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_HOLD  = 2'd2,
        ST_WAIT  = 2'd3
    } ack_st_t;
endpackage

// File: rtl/cec_edge_sampler.sv
// Samples the filtered bus level on each tick and flags a high-to-low
// change between two consecutive tick samples.
// Assumes: lvl is already synchronised and filtered.
module cec_edge_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lvl,
    output logic fall
);
    logic smp_q;

    // Keep the previous tick sample (idle bus reads high).
    always_ff @(posedge clk) begin
        if (!rst_n)    smp_q <= 1'b1;
        else if (tick) smp_q <= lvl;
    end

    // Edge is valid only on the tick that sees the low sample.
    assign fall = tick & smp_q & ~lvl;
endmodule

// File: rtl/cec_addr_gate.sv
// Decides whether the current acknowledge slot should be answered:
// header by direct address compare, data by the remembered header result.
// Assumes: capture pulses once per acknowledge edge accepted by the FSM.
module cec_addr_gate #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              hdr_blk,
    input  logic [ADDR_W-1:0] blk_dest,
    input  logic [ADDR_W-1:0] my_addr,
    output logic              resp
);
    logic match_q;
    logic hit;

    assign hit  = (blk_dest == my_addr);
    assign resp = hdr_blk ? hit : match_q;

    // Remember the header verdict for the following data blocks.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)          match_q <= 1'b0;
        else if (capture && hdr_blk)  match_q <= hit;
    end
endmodule

// File: rtl/cec_ack_fsm.sv
// Sequences the acknowledge slot: offset delay, fixed hold, then the
// watch for the following bit with a selectable timeout.
// Assumes: tick is a one-cycle enable; fall is only valid with tick.
module cec_ack_fsm
    import cec_ack_pkg::*;
#(
    parameter int HOLD_TICKS = 50,
    parameter int NC_W       = 2,
    parameter int TO_SEL_W   = 2,
    parameter int TO_UNIT    = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                fall,
    input  logic                ack_next,
    input  logic                clear,
    input  logic                resp,
    input  logic [NC_W-1:0]     nc_dly,
    input  logic [TO_SEL_W-1:0] tmo_sel,
    output logic                capture,
    output logic                pull_low,
    output logic                irq_done,
    output logic                irq_to
);
    localparam int TO_MAX = TO_UNIT * (2 ** TO_SEL_W);
    localparam int CNT_MX = (HOLD_TICKS > TO_MAX) ? HOLD_TICKS : TO_MAX;
    localparam int CNT_W  = $clog2(CNT_MX + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);

    ack_st_t          st;
    logic [CNT_W-1:0] cnt;
    logic             resp_q;
    logic [CNT_W-1:0] thr_last;
    logic [CNT_W-1:0] dly_last;

    assign thr_last = CNT_W'(TO_UNIT * (int'(tmo_sel) + 1) - 1);
    assign dly_last = CNT_W'(nc_dly) - CNT_W'(1);

    // Accept an acknowledge edge when not already inside a window.
    assign capture  = fall & ack_next & ~clear & ((st == ST_IDLE) | (st == ST_WAIT));
    assign pull_low = (st == ST_HOLD) & resp_q;

    // Main sequencer, counting in sample ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            resp_q   <= 1'b0;
            irq_done <= 1'b0;
            irq_to   <= 1'b0;
        end else begin
            irq_done <= 1'b0;
            irq_to   <= 1'b0;
            if (clear) begin
                st     <= ST_IDLE;
                cnt    <= '0;
                resp_q <= 1'b0;
            end else if (capture) begin
                resp_q <= resp;
                cnt    <= '0;
                st     <= (nc_dly == '0) ? ST_HOLD : ST_DELAY;
            end else if (tick) begin
                case (st)
                    ST_DELAY: begin
                        if (cnt == dly_last) begin
                            st  <= ST_HOLD;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (cnt == HOLD_LAST) begin
                            st       <= ST_WAIT;
                            cnt      <= '0;
                            irq_done <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WAIT: begin
                        if (fall) begin
                            st  <= ST_IDLE;
                            cnt <= '0;
                        end else if (cnt == thr_last) begin
                            st     <= ST_IDLE;
                            cnt    <= '0;
                            irq_to <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/cec_err_irq.sv
// Turns receive-error pulses into one interrupt strobe unless masked.
// Assumes: each err_in bit is a pulse from the companion receiver.
module cec_err_irq #(
    parameter int ERR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_in,
    input  logic             err_mask,
    output logic             irq_err
);
    // Register the gated OR of all error sources.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_err <= 1'b0;
        else        irq_err <= (|err_in) & ~err_mask;
    end
endmodule

// File: rtl/cec_ack_responder.sv
// Follower acknowledge generator for an open-drain control bus.
// Assumes: a companion receiver supplies start_det, ack_next, hdr_blk,
// blk_dest and err_in; the line is never driven high, only pulled low.
module cec_ack_responder #(
    parameter int ADDR_W     = 4,
    parameter int HOLD_TICKS = 50,
    parameter int NC_W       = 2,
    parameter int TO_SEL_W   = 2,
    parameter int TO_UNIT    = 48,
    parameter int ERR_W      = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_tick,
    input  logic                bus_lvl,
    input  logic                start_det,
    input  logic                ack_next,
    input  logic                hdr_blk,
    input  logic [ADDR_W-1:0]   blk_dest,
    input  logic [ADDR_W-1:0]   my_addr,
    input  logic [NC_W-1:0]     nc_dly,
    input  logic [TO_SEL_W-1:0] tmo_sel,
    input  logic                err_mask,
    input  logic [ERR_W-1:0]    err_in,
    output logic                pull_low,
    output logic                irq_ack_done,
    output logic                irq_timeout,
    output logic                irq_rx_err
);
    logic fall;
    logic capture;
    logic resp;

    cec_edge_sampler u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (smp_tick),
        .lvl   (bus_lvl),
        .fall  (fall)
    );

    cec_addr_gate #(.ADDR_W(ADDR_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_det),
        .capture  (capture),
        .hdr_blk  (hdr_blk),
        .blk_dest (blk_dest),
        .my_addr  (my_addr),
        .resp     (resp)
    );

    cec_ack_fsm #(
        .HOLD_TICKS (HOLD_TICKS),
        .NC_W       (NC_W),
        .TO_SEL_W   (TO_SEL_W),
        .TO_UNIT    (TO_UNIT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (smp_tick),
        .fall     (fall),
        .ack_next (ack_next),
        .clear    (start_det),
        .resp     (resp),
        .nc_dly   (nc_dly),
        .tmo_sel  (tmo_sel),
        .capture  (capture),
        .pull_low (pull_low),
        .irq_done (irq_ack_done),
        .irq_to   (irq_timeout)
    );

    cec_err_irq #(.ERR_W(ERR_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_in   (err_in),
        .err_mask (err_mask),
        .irq_err  (irq_rx_err)
    );
endmodule

// File: rtl/cec_ack_chk.sv
// Protocol checks on the acknowledge generator's ports.
// Assumes: bound to cec_ack_responder with its default hold length.
module cec_ack_chk #(
    parameter int HOLD_TICKS = 50
) (
    input logic clk,
    input logic rst_n,
    input logic smp_tick,
    input logic start_det,
    input logic err_mask,
    input logic pull_low,
    input logic irq_ack_done,
    input logic irq_timeout,
    input logic irq_rx_err
);
    logic [15:0] hold_ticks;

    // Count sample ticks during a continuous pull-low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n || !pull_low) hold_ticks <= '0;
        else if (smp_tick)       hold_ticks <= hold_ticks + 16'd1;
    end

    AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ticks <= 16'(HOLD_TICKS)); // R1
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_done |-> !pull_low); // R1
    AST_PULL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_tick && !start_det) |=> $stable(pull_low)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_done |=> !irq_ack_done); // R6
    AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack_done && irq_timeout)); // R6
    AST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_timeout |=> (!irq_timeout && !pull_low)); // R7
    AST_ERR_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        err_mask |=> !irq_rx_err); // R8
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!pull_low && !irq_ack_done && !irq_timeout)); // R9
endmodule

bind cec_ack_responder cec_ack_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_tick     (smp_tick),
    .start_det    (start_det),
    .err_mask     (err_mask),
    .pull_low     (pull_low),
    .irq_ack_done (irq_ack_done),
    .irq_timeout  (irq_timeout),
    .irq_rx_err   (irq_rx_err)
);

// File: tb/sim_cec_ack_responder.sv
`timescale 1ns/1ps
module sim_cec_ack_responder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_tick = 1'b0;
    logic       bus_drv = 1'b1;
    logic       bus_lvl;
    logic       start_det = 1'b0;
    logic       ack_next = 1'b0;
    logic       hdr_blk = 1'b0;
    logic [3:0] blk_dest = 4'd0;
    logic [3:0] my_addr = 4'd4;
    logic [1:0] nc_dly = 2'd0;
    logic [1:0] tmo_sel = 2'd0;
    logic       err_mask = 1'b0;
    logic [2:0] err_in = 3'd0;
    logic       pull_low, irq_ack_done, irq_timeout, irq_rx_err;

    int n_chk = 0, n_fail = 0, cyc = 0, tdiv = 0;
    int pull_clks = 0, n_ack = 0, n_to = 0;
    bit armed = 0;

    // reference model state
    int m_prev, m_mode, m_t, m_w;
    bit m_resp, m_match, m_fall;
    bit e_pull, e_ack, e_to, e_err;

    always #5 clk = ~clk;

    // open-drain wired-AND of the initiator and the block
    assign bus_lvl = bus_drv & ~pull_low;

    cec_ack_responder u0 (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .bus_lvl(bus_lvl),
        .start_det(start_det), .ack_next(ack_next), .hdr_blk(hdr_blk),
        .blk_dest(blk_dest), .my_addr(my_addr), .nc_dly(nc_dly),
        .tmo_sel(tmo_sel), .err_mask(err_mask), .err_in(err_in),
        .pull_low(pull_low), .irq_ack_done(irq_ack_done),
        .irq_timeout(irq_timeout), .irq_rx_err(irq_rx_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // tick every fourth clock
    always @(negedge clk) begin
        tdiv++;
        smp_tick <= (tdiv % 4 == 0);
    end

    // behavioural model in tick units, stepped on each clock edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_prev = 1; m_mode = 0; m_t = 0; m_w = 0;
            m_resp = 0; m_match = 0;
            e_pull = 0; e_ack = 0; e_to = 0; e_err = 0;
        end else begin
            e_ack = 0; e_to = 0;
            e_err = (err_in != 0) && !err_mask;
            m_fall = smp_tick && (m_prev == 1) && !bus_lvl;
            if (smp_tick) m_prev = bus_lvl;
            if (start_det) begin
                m_mode = 0; m_resp = 0; m_match = 0;
            end else if (m_fall && ack_next && (m_mode == 0 || m_mode == 2)) begin
                if (hdr_blk) m_match = (blk_dest == my_addr);
                m_resp = m_match;
                m_mode = 1; m_t = 0;
            end else if (smp_tick) begin
                if (m_mode == 1) begin
                    m_t++;
                    if (m_t == nc_dly + 50) begin
                        m_mode = 2; m_w = 0; e_ack = 1;
                    end
                end else if (m_mode == 2) begin
                    if (m_fall) m_mode = 0;
                    else begin
                        m_w++;
                        if (m_w == 48 * (tmo_sel + 1)) begin
                            m_mode = 0; e_to = 1;
                        end
                    end
                end
            end
            e_pull = (m_mode == 1) && m_resp && (m_t >= nc_dly) && (m_t < nc_dly + 50);
        end
    end

    // per-clock comparison and event monitors
    always @(negedge clk) begin
        if (armed && rst_n) begin
            chk(pull_low == e_pull, "R1 R2 R3 R4 R5 pull_low", pull_low, e_pull);
            chk(irq_ack_done == e_ack, "R6 irq_ack_done", irq_ack_done, e_ack);
            chk(irq_timeout == e_to, "R7 irq_timeout", irq_timeout, e_to);
            chk(irq_rx_err == e_err, "R8 irq_rx_err", irq_rx_err, e_err);
        end
        if (pull_low) pull_clks++;
        if (irq_ack_done) n_ack++;
        if (irq_timeout) n_to++;
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("[TB] FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    // acknowledge bit from the initiator; checks drive length
    task automatic ack_bit(input bit hdr, input logic [3:0] dst, input int exp_clks, input string tag);
        int a0;
        a0 = n_ack;
        pull_clks = 0;
        @(negedge clk);
        ack_next = 1; hdr_blk = hdr; blk_dest = dst; bus_drv = 0;
        ticks(20);
        bus_drv = 1; ack_next = 0;
        ticks(40);
        chk(pull_clks == exp_clks, tag, pull_clks, exp_clks);
        chk(n_ack == a0 + 1, "R6 window done count", n_ack - a0, 1);
    endtask

    // an ordinary following bit with no acknowledge expectation
    task automatic data_bit();
        @(negedge clk);
        bus_drv = 0; ticks(10);
        bus_drv = 1; ticks(20);
    endtask

    initial begin
        int t0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        armed = 1;
        @(negedge clk);
        // R9 reset state
        chk(!pull_low && !irq_ack_done && !irq_timeout && !irq_rx_err,
            "R9 reset outputs", {pull_low, irq_ack_done, irq_timeout, irq_rx_err}, 0);

        // R1 R3 matching header, no offset
        ack_bit(1, 4'd4, 200, "R1 header match hold clocks");
        t0 = n_to;
        data_bit();
        chk(n_to == t0, "R7 edge cancels timeout", n_to - t0, 0);
        // R4 data after matched header
        ack_bit(0, 4'd9, 200, "R4 data after match");
        ticks(60);
        chk(n_to == t0 + 1, "R7 timeout sel 0", n_to - t0, 1);

        // R2 maximum noise-cancel offset
        nc_dly = 2'd3;
        ack_bit(1, 4'd4, 200, "R2 offset 3 hold clocks");
        ticks(60);

        // R3 mismatch, then R4 data stays released
        nc_dly = 2'd1;
        ack_bit(1, 4'd5, 0, "R3 header mismatch no drive");
        ack_bit(0, 4'd4, 0, "R4 data after mismatch");
        ticks(60);

        // R9 start bit aborts a drive and clears the match memory
        nc_dly = 2'd0;
        @(negedge clk);
        ack_next = 1; hdr_blk = 1; blk_dest = 4'd4; bus_drv = 0;
        ticks(5);
        chk(pull_low == 1, "R9 drive active before abort", pull_low, 1);
        start_det = 1;
        @(negedge clk);
        start_det = 0;
        chk(pull_low == 0, "R9 released after start", pull_low, 0);
        ack_next = 0;
        ticks(15);
        bus_drv = 1;
        ticks(5);
        ack_bit(0, 4'd4, 0, "R9 data after abort not acked");
        ticks(60);

        // R8 error interrupt per source bit, then masked
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            err_in = 3'(1 << i);
            @(negedge clk);
            err_in = 3'd0;
            chk(irq_rx_err == 1, "R8 error bit unmasked", irq_rx_err, 1);
        end
        err_mask = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            err_in = 3'(1 << i);
            @(negedge clk);
            err_in = 3'd0;
            chk(irq_rx_err == 0, "R8 error bit masked", irq_rx_err, 0);
        end
        err_mask = 0;

        // R7 longest timeout
        tmo_sel = 2'd3;
        ack_bit(1, 4'd4, 200, "R1 hold with long timeout");
        t0 = n_to;
        ticks(150);
        chk(n_to == t0, "R7 no timeout before 192 ticks", n_to - t0, 0);
        ticks(50);
        chk(n_to == t0 + 1, "R7 timeout sel 3", n_to - t0, 1);
        tmo_sel = 2'd0;

        // R5 low already present, no high sample before it
        pull_clks = 0;
        @(negedge clk);
        bus_drv = 0; ticks(10);
        ack_next = 1; hdr_blk = 1; blk_dest = 4'd4; ticks(10);
        bus_drv = 1; ack_next = 0; ticks(10);
        chk(pull_clks == 0, "R5 low without prior high", pull_clks, 0);

        // R5 glitch between two ticks
        pull_clks = 0;
        @(negedge clk);
        while (!smp_tick) @(negedge clk);
        ack_next = 1; hdr_blk = 1; blk_dest = 4'd4;
        @(negedge clk);
        bus_drv = 0;
        repeat (2) @(negedge clk);
        bus_drv = 1;
        ticks(5);
        ack_next = 0;
        chk(pull_clks == 0, "R5 glitch between ticks", pull_clks, 0);

        // R5 real edge but no acknowledge flag
        data_bit();
        chk(pull_clks == 0, "R5 edge without ack flag", pull_clks, 0);

        ticks(5);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule